// File: doc/BRIEF.md
# DMA Write Cache-Line Splitter

The splitter takes one inbound posted memory write at a time and breaks it into write requests for a line-organised cache. A request gives a byte start address, a length in 32-bit dwords, byte enables for the first and the last dword, and a tag. The payload then arrives as a stream of dwords with a valid/ready handshake. Each write the block produces is either a whole 64-byte line or an 8-byte partial write with a byte mask. Each write also carries a hashed address, a bank index, the tag, a fixed write opcode and a flag that marks the last write into a line.

A write that starts in the middle of a line is first brought up to the line boundary with 8-byte writes. Aligned stretches then go out as whole lines where the remaining length allows. The remainder finishes with 8-byte writes. Address hashing and a remap of the bank index for parts with only some bank pairs fitted are configured through static inputs. The result goes out through a registered valid/ready port. While that port is back-pressured, the payload stream is held.

Top module: `dma_line_splitter`

## Requirements
- R1: When the start address is not on a 64-byte line boundary and the length is greater than the dwords left to the line end, (64 - offset + 3) / 4, the dwords up to the boundary go out as 8-byte writes before any whole-line write.
- R2: At a line-aligned dword address, a whole-line write is produced when more than 16 dwords remain, or when exactly 16 remain and the last-dword byte enable is 4'b1111. Every other remainder goes out as 8-byte writes.
- R3: A whole-line write has out_full=1, a mask of 8'h00 and out_last=1. Its 512-bit data holds the line's first dword in bits [511:480], the next in [479:448], and so on down.
- R4: An 8-byte write has out_full=0 and its address aligned down to 8 bytes. A dword whose address bit 2 is 0 sits in data bits [63:32] under mask bits [7:4]. A dword whose address bit 2 is 1 sits in [31:0] under mask [3:0]. A half that holds no dword has zero data and zero mask, and data bits above 63 are zero.
- R5: The mask nibble of the request's first dword is its first byte enable with bit order reversed (be[0] goes to the nibble's top bit). This rule wins for a one-dword request. The mask nibble of the final dword is the last byte enable reversed the same way. Every other dword gets 4'b1111.
- R6: out_last is 1 on an 8-byte write that holds the request's final dword, or that holds a dword whose address bits [5:2] are 4'b1111. Otherwise it is 0.
- R7: Every write carries out_opcode = 4'b1101 and the tag of its request.
- R8: When hash_en=1 and address bit 39 is 0, the output address bits [17:13] are addr[32:28] ^ addr[17:13], and bits [12:11] are addr[19:18] ^ addr[12:11]. All other bits, and every bit when the condition is false, pass unchanged.
- R9: out_bank is address bits [8:6] before hashing. With pbank_en=1, bank bits [2:1] are remapped by pbank_code: 0001→00, 0010→01, 0011→{0,b1}, 0100→10, 0101→{b1,0}, 0110→{b1,~b1}, 1000→11, 1001→{b1,b1}, 1010→{b1,1}, 1100→{1,b1}, 1111→unchanged. Bank bit 0 is never changed.
- R10: A one-dword request with first byte enable 4'b0000 produces no write. Its single payload dword is still consumed, so the next request lines up with its own payload.
- R11: When a write is produced while pbank_en=1 and pbank_code is not in the R9 list, bank_err is set and stays 1 until reset, and that write's bank is the unmapped bits [8:6].
- R12: While out_valid=1 and out_ready=0, pl_ready is 0 and every output field holds its value.
- R13: After reset, out_valid=0, bank_err=0, pl_ready=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hash_en | input | 1 | Enables address hashing |
| pbank_en | input | 1 | Enables bank-pair remapping |
| pbank_code | input | 4 | Fitted bank-pair code |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (block idle) |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Length in dwords, 1 or more |
| req_first_be | input | 4 | Byte enables of first dword |
| req_last_be | input | 4 | Byte enables of final dword |
| req_tag | input | TAG_W | Request tag |
| pl_valid | input | 1 | Payload dword offered |
| pl_ready | output | 1 | Payload dword accepted |
| pl_data | input | 32 | Payload dword |
| out_valid | output | 1 | Write request valid |
| out_ready | input | 1 | Write request taken |
| out_full | output | 1 | 1 for a whole-line write |
| out_addr | output | ADDR_W | Hashed write address |
| out_bank | output | BANK_W | Bank index |
| out_tag | output | TAG_W | Tag of the request |
| out_opcode | output | 4 | Write opcode |
| out_mask | output | 8 | Byte mask (zero for whole lines) |
| out_data | output | LINE_BYTES*8 | Write data |
| out_last | output | 1 | Last write into this line |
| bank_err | output | 1 | Sticky illegal bank-code flag |

## Verification
Two things can happen in the same cycle: the output register is held by back-pressure while the payload stream offers the next segment's dword. The bench drives out_ready from a pseudo-random sequence and offers payload almost every cycle, so the two meet often. Each cycle it counts any accepted payload dword while the output is stalled, and any change to a held output. A scoreboard compares every produced write, field by field, against a model built from the requirements. A dword taken during a stall, or a write that was overwritten, shows up as a mismatch or a missing item.

// File: rtl/dls_pkg.sv
package dls_pkg;

  localparam logic [3:0] WR_OPCODE = 4'b1101;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLAN,
    ST_GATHER,
    ST_EMIT
  } dls_state_e;

  // byte-enable nibble placed in mask order: enable bit 0 lands on the top mask bit
  function automatic logic [3:0] flip_be(input logic [3:0] be);
    return {be[0], be[1], be[2], be[3]};
  endfunction

endpackage

// File: rtl/dls_plan.sv
// Chooses the shape of the next segment from the current dword offset in the line.
module dls_plan #(
  parameter int LEN_W   = 11,
  parameter int LINE_DW = 16,
  parameter int OFS_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [LEN_W-1:0] rem,
  input  logic [3:0]       last_be,
  output logic             full,
  output logic [CNT_W-1:0] cnt
);

  logic aligned;
  logic many;
  logic exact;

  assign aligned = (ofs == '0);
  assign many    = rem > LEN_W'(LINE_DW);
  assign exact   = (rem == LEN_W'(LINE_DW)) && (&last_be);
  assign full    = aligned && (many || exact);

  always_comb begin
    if (full)
      cnt = CNT_W'(LINE_DW);
    else if (!ofs[0] && (rem >= LEN_W'(2)))
      cnt = CNT_W'(2);
    else
      cnt = CNT_W'(1);
  end

endmodule

// File: rtl/dls_lane.sv
// Mask nibble for one dword of an 8-byte write.
module dls_lane
  import dls_pkg::*;
(
  input  logic       is_first,
  input  logic       is_final,
  input  logic [3:0] first_be,
  input  logic [3:0] last_be,
  output logic [3:0] nib
);

  always_comb begin
    if (is_first)
      nib = flip_be(first_be);
    else if (is_final)
      nib = flip_be(last_be);
    else
      nib = 4'hF;
  end

endmodule

// File: rtl/dls_route.sv
// Address hash and bank-index remap for one outgoing write.
module dls_route #(
  parameter int ADDR_W   = 40,
  parameter int BANK_LSB = 6,
  parameter int BANK_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hash_en,
  input  logic              pbank_en,
  input  logic [3:0]        pbank_code,
  output logic [ADDR_W-1:0] addr_hashed,
  output logic [BANK_W-1:0] bank,
  output logic              code_bad
);

  logic [BANK_W-1:0] raw;
  assign raw = addr[BANK_LSB +: BANK_W];

  always_comb begin
    addr_hashed = addr;
    if (hash_en && !addr[ADDR_W-1]) begin
      addr_hashed[17:13] = addr[32:28] ^ addr[17:13];
      addr_hashed[12:11] = addr[19:18] ^ addr[12:11];
    end
  end

  always_comb begin
    bank     = raw;
    code_bad = 1'b0;
    if (pbank_en) begin
      case (pbank_code)
        4'b0001: bank[2:1] = 2'b00;
        4'b0010: bank[2:1] = 2'b01;
        4'b0011: bank[2]   = 1'b0;
        4'b0100: bank[2:1] = 2'b10;
        4'b0101: bank[2:1] = {raw[1], 1'b0};
        4'b0110: bank[2:1] = {raw[1], ~raw[1]};
        4'b1000: bank[2:1] = 2'b11;
        4'b1001: bank[2:1] = {raw[1], raw[1]};
        4'b1010: bank[2:1] = {raw[1], 1'b1};
        4'b1100: bank[2:1] = {1'b1, raw[1]};
        4'b1111: bank      = raw;
        default: code_bad  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
  import dls_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LEN_W      = 11,
  parameter int TAG_W      = 8,
  parameter int LINE_BYTES = 64,
  parameter int BANK_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hash_en,
  input  logic                    pbank_en,
  input  logic [3:0]              pbank_code,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [3:0]              req_first_be,
  input  logic [3:0]              req_last_be,
  input  logic [TAG_W-1:0]        req_tag,
  input  logic                    pl_valid,
  output logic                    pl_ready,
  input  logic [31:0]             pl_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_full,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [BANK_W-1:0]       out_bank,
  output logic [TAG_W-1:0]        out_tag,
  output logic [3:0]              out_opcode,
  output logic [7:0]              out_mask,
  output logic [LINE_BYTES*8-1:0] out_data,
  output logic                    out_last,
  output logic                    bank_err
);

  localparam int LINE_DW   = LINE_BYTES / 4;
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int OFS_W     = $clog2(LINE_DW);
  localparam int BANK_LSB  = $clog2(LINE_BYTES);
  localparam int DWA_W     = ADDR_W - 2;
  localparam int CNT_W     = $clog2(LINE_DW + 1);

  dls_state_e          state;
  logic [DWA_W-1:0]    cur_dw;
  logic [DWA_W-1:0]    seg_dw;
  logic [LEN_W-1:0]    rem;
  logic [3:0]          fbe_q;
  logic [3:0]          lbe_q;
  logic [TAG_W-1:0]    tag_q;
  logic                is_first;
  logic                drop_q;
  logic                seg_full;
  logic                seg_last;
  logic [CNT_W-1:0]    seg_cnt;
  logic [CNT_W-1:0]    got;
  logic [1:0][3:0]     pnib;

  logic                plan_full;
  logic [CNT_W-1:0]    plan_cnt;
  logic [3:0]          nib;
  logic                pl_fire;
  logic                out_free;
  logic                seg_clr;
  logic [OFS_W-1:0]    slot;
  logic [ADDR_W-1:0]   seg_addr;
  logic [ADDR_W-1:0]   hashed;
  logic [BANK_W-1:0]   bank_sel;
  logic                code_bad;
  logic [LINE_DW-1:0][31:0] words;
  logic [LINE_BITS-1:0] line_word;
  logic [LINE_BITS-1:0] data_next;

  assign req_ready = (state == ST_IDLE);
  assign out_free  = !out_valid || out_ready;
  assign pl_ready  = (state == ST_GATHER) && out_free;
  assign pl_fire   = pl_valid && pl_ready;
  assign seg_clr   = (state == ST_PLAN);
  assign slot      = seg_full ? got[OFS_W-1:0] : OFS_W'(cur_dw[0]);

  dls_plan #(
    .LEN_W  (LEN_W),
    .LINE_DW(LINE_DW),
    .OFS_W  (OFS_W),
    .CNT_W  (CNT_W)
  ) u_plan (
    .ofs    (cur_dw[OFS_W-1:0]),
    .rem    (rem),
    .last_be(lbe_q),
    .full   (plan_full),
    .cnt    (plan_cnt)
  );

  dls_lane u_lane (
    .is_first(is_first),
    .is_final(rem == LEN_W'(1)),
    .first_be(fbe_q),
    .last_be (lbe_q),
    .nib     (nib)
  );

  // one dword register per line slot; partial writes use slots 0 (upper) and 1 (lower)
  for (genvar k = 0; k < LINE_DW; k++) begin : g_slot
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (seg_clr)
        word_q <= '0;
      else if (pl_fire && (slot == OFS_W'(k)))
        word_q <= pl_data;
    end
    assign words[k] = word_q;
    assign line_word[LINE_BITS-1-32*k -: 32] = word_q;
  end

  assign data_next = seg_full ? line_word : LINE_BITS'({words[0], words[1]});
  assign seg_addr  = seg_full ? {seg_dw[DWA_W-1:OFS_W], {(OFS_W+2){1'b0}}}
                              : {seg_dw[DWA_W-1:1], 3'b000};

  dls_route #(
    .ADDR_W  (ADDR_W),
    .BANK_LSB(BANK_LSB),
    .BANK_W  (BANK_W)
  ) u_route (
    .addr       (seg_addr),
    .hash_en    (hash_en),
    .pbank_en   (pbank_en),
    .pbank_code (pbank_code),
    .addr_hashed(hashed),
    .bank       (bank_sel),
    .code_bad   (code_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_dw     <= '0;
      seg_dw     <= '0;
      rem        <= '0;
      fbe_q      <= '0;
      lbe_q      <= '0;
      tag_q      <= '0;
      is_first   <= 1'b0;
      drop_q     <= 1'b0;
      seg_full   <= 1'b0;
      seg_last   <= 1'b0;
      seg_cnt    <= '0;
      got        <= '0;
      pnib       <= '0;
      out_valid  <= 1'b0;
      out_full   <= 1'b0;
      out_addr   <= '0;
      out_bank   <= '0;
      out_tag    <= '0;
      out_opcode <= '0;
      out_mask   <= '0;
      out_data   <= '0;
      out_last   <= 1'b0;
      bank_err   <= 1'b0;
    end else begin
      if (out_valid && out_ready)
        out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_dw   <= req_addr[ADDR_W-1:2];
            rem      <= req_len;
            fbe_q    <= req_first_be;
            lbe_q    <= req_last_be;
            tag_q    <= req_tag;
            is_first <= 1'b1;
            drop_q   <= (req_len == LEN_W'(1)) && (req_first_be == 4'h0);
            state    <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          seg_dw   <= cur_dw;
          seg_full <= plan_full;
          seg_cnt  <= plan_cnt;
          seg_last <= plan_full;
          got      <= '0;
          pnib     <= '0;
          state    <= ST_GATHER;
        end
        ST_GATHER: begin
          if (pl_fire) begin
            cur_dw   <= cur_dw + DWA_W'(1);
            rem      <= rem - LEN_W'(1);
            is_first <= 1'b0;
            got      <= got + CNT_W'(1);
            if (!seg_full)
              pnib[cur_dw[0]] <= nib;
            if ((rem == LEN_W'(1)) || (&cur_dw[OFS_W-1:0]))
              seg_last <= 1'b1;
            if ((got + CNT_W'(1)) == seg_cnt)
              state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_free) begin
            if (!drop_q) begin
              out_valid  <= 1'b1;
              out_full   <= seg_full;
              out_addr   <= hashed;
              out_bank   <= bank_sel;
              out_tag    <= tag_q;
              out_opcode <= WR_OPCODE;
              out_mask   <= seg_full ? 8'h00 : {pnib[0], pnib[1]};
              out_data   <= data_next;
              out_last   <= seg_last;
              if (code_bad)
                bank_err <= 1'b1;
            end
            state <= (rem == '0) ? ST_IDLE : ST_PLAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_ready,
  input logic                    pl_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_full,
  input logic [7:0]              out_mask,
  input logic                    out_last,
  input logic [LINE_BYTES*8-1:0] out_data,
  input logic [ADDR_W-1:0]       out_addr,
  input logic [3:0]              out_opcode,
  input logic                    bank_err
);

  p_stall_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !pl_ready);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)
                                   && $stable(out_mask) && $stable(out_last)));

  p_line_shape_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_full) |-> ((out_mask == 8'h00) && out_last));

  p_opcode_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_opcode == 4'b1101));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    bank_err |=> bank_err);

  p_idle_no_payload_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !pl_ready);

endmodule

bind dma_line_splitter dls_checker #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES)
) u_dls_checker (.*);

// File: tb/test_dma_line_splitter.sv
module test_dma_line_splitter;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic         full;
    logic [39:0]  addr;
    logic [2:0]   bank;
    logic [7:0]   mask;
    logic [511:0] data;
    logic         last;
    logic [7:0]   tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hash_en = 1'b0, pbank_en = 1'b0;
  logic [3:0] pbank_code = 4'hF;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [39:0] req_addr = '0;
  logic [10:0] req_len = '0;
  logic [3:0] req_first_be = '0, req_last_be = '0;
  logic [7:0] req_tag = '0;
  logic pl_valid = 1'b0;
  logic pl_ready;
  logic [31:0] pl_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_full;
  logic [39:0] out_addr;
  logic [2:0] out_bank;
  logic [7:0] out_tag;
  logic [3:0] out_opcode;
  logic [7:0] out_mask;
  logic [511:0] out_data;
  logic out_last;
  logic bank_err;

  exp_t q[$];
  int n_chk = 0, n_err = 0, seq = 0, stall_viol = 0, hold_viol = 0;
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'h5B;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_line_splitter i_dma_line_splitter (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int b, input int k);
    return {b[15:0] ^ 16'hA5C3, k[15:0] ^ 16'h0F00};
  endfunction

  function automatic logic [3:0] rev(input logic [3:0] v);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[3-i] = v[i];
    return r;
  endfunction

  function automatic logic [39:0] ehash(input logic [39:0] a);
    logic [39:0] h;
    h = a;
    if (hash_en && a[39] == 1'b0) begin
      h[17:13] = h[17:13] ^ a[32:28];
      h[12:11] = h[12:11] ^ a[19:18];
    end
    return h;
  endfunction

  function automatic logic [2:0] ebank(input logic [39:0] a);
    logic [2:0] b;
    logic [1:0] hi;
    b = a[8:6];
    hi = b[2:1];
    if (pbank_en) begin
      case (pbank_code)
        4'd1:  hi = 2'd0;
        4'd2:  hi = 2'd1;
        4'd3:  hi = {1'b0, b[1]};
        4'd4:  hi = 2'd2;
        4'd5:  hi = {b[1], 1'b0};
        4'd6:  hi = {b[1], !b[1]};
        4'd8:  hi = 2'd3;
        4'd9:  hi = {2{b[1]}};
        4'd10: hi = {b[1], 1'b1};
        4'd12: hi = {1'b1, b[1]};
        default: hi = b[2:1];
      endcase
    end
    return {hi, b[0]};
  endfunction

  // expected writes per R1..R10
  task automatic model(input logic [39:0] a, input int len, input logic [3:0] fb,
                       input logic [3:0] lb, input logic [7:0] tg, input int base);
    logic [37:0] dw;
    int rem, k;
    exp_t e;
    logic [3:0] n;
    bit more;
    dw = a[39:2];
    rem = len;
    k = 0;
    if (len == 1 && fb == 4'h0) return;
    while (rem > 0) begin
      e = '0;
      e.tag = tg;
      if (dw[3:0] == 4'h0 && (rem > 16 || (rem == 16 && lb == 4'hF))) begin
        e.full = 1'b1;
        e.last = 1'b1;
        e.addr = {dw[37:4], 6'h0};
        for (int j = 0; j < 16; j++) e.data[511-32*j -: 32] = pay(base, k + j);
        k += 16;
        dw += 38'd16;
        rem -= 16;
      end else begin
        e.addr = {dw[37:1], 3'h0};
        more = 1'b1;
        while (more) begin
          n = (k == 0) ? rev(fb) : ((rem == 1) ? rev(lb) : 4'hF);
          if (dw[0]) begin
            e.data[31:0] = pay(base, k);
            e.mask[3:0] = n;
          end else begin
            e.data[63:32] = pay(base, k);
            e.mask[7:4] = n;
          end
          if (rem == 1 || dw[3:0] == 4'hF) e.last = 1'b1;
          more = !dw[0] && rem > 1;
          k++;
          dw += 38'd1;
          rem--;
        end
      end
      e.bank = ebank(e.addr);
      e.addr = ehash(e.addr);
      q.push_back(e);
    end
  endtask

  task automatic send_req(input logic [39:0] a, input int len, input logic [3:0] fb,
                          input logic [3:0] lb, input logic [7:0] tg);
    int base;
    seq++;
    base = seq;
    model(a, len, fb, lb, tg, base);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    req_len = 11'(len);
    req_first_be = fb;
    req_last_be = lb;
    req_tag = tg;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      if ((base + k) % 5 == 3) @(negedge clk);
      @(negedge clk);
      pl_valid = 1'b1;
      pl_data = pay(base, k);
      #1;
      while (!pl_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1 pl_valid = 1'b0;
    end
  endtask

  task automatic drain();
    while (q.size() > 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // monitor and scoreboard
  initial begin
    exp_t e;
    bit prev_stall;
    logic [511:0] prev_data;
    prev_stall = 1'b0;
    prev_data = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
      #1;
      if (rst) begin
        prev_stall = 1'b0;
      end else begin
        if (prev_stall && (!out_valid || out_data != prev_data)) hold_viol++;
        if (out_valid && !out_ready && pl_ready) stall_viol++;
        prev_stall = out_valid && !out_ready;
        prev_data = out_data;
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected write addr", 512'(out_addr), 512'(0));
          end else begin
            e = q.pop_front();
            chk(out_full == e.full, "R2", "full", 512'(out_full), 512'(e.full));
            chk(out_addr == e.addr, "R8", "addr", 512'(out_addr), 512'(e.addr));
            chk(out_bank == e.bank, "R9", "bank", 512'(out_bank), 512'(e.bank));
            chk(out_mask == e.mask, "R5", "mask", 512'(out_mask), 512'(e.mask));
            chk(out_data == e.data, "R4", "data", out_data, e.data);
            chk(out_last == e.last, "R6", "last", 512'(out_last), 512'(e.last));
            chk(out_tag == e.tag && out_opcode == 4'b1101, "R7", "tag/opcode",
                512'({out_tag, out_opcode}), 512'({e.tag, 4'b1101}));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R12 watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R13", "out_valid", 512'(out_valid), 512'(0));
    chk(req_ready == 1'b1, "R13", "req_ready", 512'(req_ready), 512'(1));
    chk(pl_ready == 1'b0, "R13", "pl_ready", 512'(pl_ready), 512'(0));
    chk(bank_err == 1'b0, "R13", "bank_err", 512'(bank_err), 512'(0));

    // R4 R5 aligned short write
    send_req(40'h00_0000_1000, 4, 4'hF, 4'hF, 8'h11); drain();
    // R2 R3 exactly one line with full last enables
    send_req(40'h00_0000_2000, 16, 4'h3, 4'hF, 8'h12); drain();
    // R2 exactly 16 dwords but last enable partial
    send_req(40'h00_0000_2040, 16, 4'hF, 4'h7, 8'h13); drain();
    bp_on = 1'b1;
    // R1 R6 head to boundary, one line, tail
    send_req(40'h00_0000_3034, 20, 4'h6, 4'hC, 8'h14); drain();
    send_req(40'h00_0000_4008, 33, 4'h8, 4'h1, 8'h15); drain();
    send_req(40'h00_0000_5000, 33, 4'hE, 4'h0, 8'h16); drain();
    // R5 one dword in upper address half
    send_req(40'h00_0000_6004, 1, 4'h3, 4'h0, 8'h17); drain();
    // R10 dropped single dword, next request must use its own payload
    send_req(40'h00_0000_6100, 1, 4'h0, 4'hF, 8'h18); drain();
    chk(req_ready == 1'b1, "R10", "idle after drop", 512'(req_ready), 512'(1));
    send_req(40'h00_0000_6200, 2, 4'h5, 4'hA, 8'h19); drain();
    // R8 hashing with bit 39 clear and set
    hash_en = 1'b1;
    send_req(40'h01_2345_6780, 8, 4'hF, 4'hF, 8'h1A); drain();
    send_req(40'h01_F00C_0000, 20, 4'hF, 4'hF, 8'h1B); drain();
    send_req(40'h80_1234_5600, 4, 4'hF, 4'hF, 8'h1C); drain();
    hash_en = 1'b0;
    // R9 bank-pair remaps
    pbank_en = 1'b1;
    pbank_code = 4'b0110; send_req(40'h00_0000_01C0, 20, 4'hF, 4'hF, 8'h1D); drain();
    pbank_code = 4'b0101; send_req(40'h00_0000_0080, 4, 4'hF, 4'hF, 8'h1E); drain();
    pbank_code = 4'b1001; send_req(40'h00_0000_0140, 4, 4'hF, 4'hF, 8'h1F); drain();
    pbank_code = 4'b1111; send_req(40'h00_0000_0180, 4, 4'hF, 4'hF, 8'h20); drain();
    chk(bank_err == 1'b0, "R11", "no error on legal codes", 512'(bank_err), 512'(0));
    // R11 illegal code then legal one: flag stays
    pbank_code = 4'b0111; send_req(40'h00_0000_01C0, 2, 4'hF, 4'hF, 8'h21); drain();
    chk(bank_err == 1'b1, "R11", "error set", 512'(bank_err), 512'(1));
    pbank_code = 4'b0001; send_req(40'h00_0000_00C0, 2, 4'hF, 4'hF, 8'h22); drain();
    chk(bank_err == 1'b1, "R11", "error sticky", 512'(bank_err), 512'(1));
    pbank_en = 1'b0;
    bp_on = 1'b0;

    chk(stall_viol == 0, "R12", "payload taken while stalled", 512'(stall_viol), 512'(0));
    chk(hold_viol == 0, "R12", "output changed while stalled", 512'(hold_viol), 512'(0));
    chk(q.size() == 0, "R2", "writes outstanding", 512'(q.size()), 512'(0));
    summary();
    $finish;
  end

endmodule